// File: doc/BRIEF.md
# Stepper Driver Fault and Power-State Supervisor

This block decides, every clock cycle, whether the power stage of a two-winding stepper driver may conduct, and when the step translator must be forced back to its home position. It combines the host's output-disable pin, the sleep pin and the active-low translator reset pin with digital fault flags from the analog detectors: an over-current event with a short-to-ground qualifier, over-temperature and undervoltage. The translator and the current chopper are separate blocks that take `out_en_o` and `home_rst_o` from here.

The output-disable pin is a pure gate on the power stage. Stepping, direction and resolution handling, and therefore `home_rst_o` and `step_block_o`, do not depend on it. A short to ground is held in a latch that only a fresh wake from sleep or a power-on reset can clear. Thermal and undervoltage faults are not latched: they hold the outputs off and the translator at home only while present. Leaving sleep starts a wake-up delay, counted in clock cycles, that lets the gate supply settle before steps are accepted and outputs are driven.

Top module: `stepper_fault_supervisor`

## Requirements
- R1: `out_en_o` is high in a cycle exactly when the disable pin is low, sleep is high, the reset pin is high, no short is latched, the thermal and undervoltage flags are low, and the wake delay has expired. It follows these inputs in the same cycle, with no register on the way.
- R2: The disable pin affects only `out_en_o`. Raising it never changes `home_rst_o`, `step_block_o`, `fault_latched_o` or the wake count.
- R3: While sleep is low, `step_block_o` is high and the wake count is reloaded. After sleep returns high, `step_block_o` stays high for exactly WAKE_CYCLES rising edges that sample sleep high, and then goes low.
- R4: A rising edge that samples `ocp_evt_i` and `ocp_gnd_i` both high sets `fault_latched_o`. The latch then stays set even after the flags drop and through any activity on the disable pin or the reset pin.
- R5: The short latch clears on the first rising edge that samples sleep high after an edge that sampled it low. If a short event is sampled on that same edge, the latch stays set, because setting takes priority over clearing.
- R6: The thermal and undervoltage flags force `out_en_o` low only while they are high. They set no latch, and outputs return in the same cycle the flag drops, with no wake delay.
- R7: `home_rst_o` is registered. It is high in the cycle after an edge that sampled any of these: reset pin low, sleep low, thermal flag, undervoltage flag, or any over-current event (shorted or not).
- R8: `fault_code_o` reports the dominant cause: 0 none, 1 short latched, 2 thermal, 3 undervoltage, with priority short over thermal over undervoltage.
- R9: While power-on reset is asserted and just after it is released: `fault_latched_o` is low, `home_rst_o` is high, and `step_block_o` is high with `out_en_o` low until the wake delay has run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| drv_disable_i | input | 1 | Output-disable pin, high turns the power stage off |
| sleep_n_i | input | 1 | Sleep pin, low puts the driver to sleep |
| xlat_rst_n_i | input | 1 | Translator reset pin, active low |
| ocp_evt_i | input | 1 | Over-current detected on either bridge |
| ocp_gnd_i | input | 1 | Qualifies the over-current as a short to ground |
| ot_flag_i | input | 1 | Over-temperature flag |
| uv_flag_i | input | 1 | Undervoltage flag |
| out_en_o | output | 1 | Global power-stage enable |
| home_rst_o | output | 1 | Forces the translator to its home position |
| step_block_o | output | 1 | Step pulses must be ignored (asleep or waking) |
| fault_latched_o | output | 1 | Short-to-ground latch state |
| fault_code_o | output | 2 | Dominant fault cause, encoded as in R8 |

## Verification
The short latch can be set and cleared on the same edge. This happens when a short-to-ground event arrives in the first cycle after sleep is released. The bench provokes it by raising sleep and both over-current flags together after a sleep interval, then checks that `fault_latched_o` is still high and `fault_code_o` still reads 1 one edge later. A second collision comes from the wake counter finishing while a thermal or disable input is active. In that case the bench checks that the expiry of the delay does not enable the outputs, and that `step_block_o` still drops on the expected edge.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_SHORT = 2'd1,
        FLT_THERM = 2'd2,
        FLT_UVOLT = 2'd3
    } fault_e;
endpackage

// File: rtl/sfs_wake_timer.sv
module sfs_wake_timer #(
    parameter int WAKE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n_i,
    output logic ready_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wake_st_t;

    wake_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sleep_n_i) begin
            st_d.cnt = CW'(WAKE_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: CW'(WAKE_CYCLES)};
        else        st_q <= st_d;
    end

    assign ready_o = (st_q.cnt == '0);
endmodule

// File: rtl/sfs_short_latch.sv
module sfs_short_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n_i,
    input  logic ocp_evt_i,
    input  logic ocp_gnd_i,
    output logic latched_o
);
    typedef struct packed {
        logic latched;
        logic sleep_seen;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic      wake_edge;
    logic      short_evt;

    always_comb begin
        wake_edge     = sleep_n_i && !st_q.sleep_seen;
        short_evt     = ocp_evt_i && ocp_gnd_i;
        st_d          = st_q;
        st_d.sleep_seen = sleep_n_i;
        if (short_evt)      st_d.latched = 1'b1;
        else if (wake_edge) st_d.latched = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{latched: 1'b0, sleep_seen: 1'b1};
        else        st_q <= st_d;
    end

    assign latched_o = st_q.latched;
endmodule

// File: rtl/sfs_out_gate.sv
module sfs_out_gate
    import sfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drv_disable_i,
    input  logic       sleep_n_i,
    input  logic       xlat_rst_n_i,
    input  logic       ocp_evt_i,
    input  logic       ot_flag_i,
    input  logic       uv_flag_i,
    input  logic       latched_i,
    input  logic       ready_i,
    output logic       out_en_o,
    output logic       home_rst_o,
    output logic       step_block_o,
    output logic [1:0] fault_code_o
);
    typedef struct packed {
        logic home;
    } gate_st_t;

    gate_st_t st_d, st_q;
    fault_e   code;

    always_comb begin
        st_d      = st_q;
        st_d.home = !xlat_rst_n_i || !sleep_n_i || ot_flag_i || uv_flag_i || ocp_evt_i;

        if (latched_i)      code = FLT_SHORT;
        else if (ot_flag_i) code = FLT_THERM;
        else if (uv_flag_i) code = FLT_UVOLT;
        else                code = FLT_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{home: 1'b1};
        else        st_q <= st_d;
    end

    assign out_en_o     = !drv_disable_i && sleep_n_i && xlat_rst_n_i && !latched_i
                          && !ot_flag_i && !uv_flag_i && ready_i;
    assign home_rst_o   = st_q.home;
    assign step_block_o = !sleep_n_i || !ready_i;
    assign fault_code_o = code;
endmodule

// File: rtl/stepper_fault_supervisor.sv
module stepper_fault_supervisor #(
    parameter int WAKE_CYCLES = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drv_disable_i,
    input  logic       sleep_n_i,
    input  logic       xlat_rst_n_i,
    input  logic       ocp_evt_i,
    input  logic       ocp_gnd_i,
    input  logic       ot_flag_i,
    input  logic       uv_flag_i,
    output logic       out_en_o,
    output logic       home_rst_o,
    output logic       step_block_o,
    output logic       fault_latched_o,
    output logic [1:0] fault_code_o
);
    logic ready;
    logic latched;

    sfs_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_n_i (sleep_n_i),
        .ready_o   (ready)
    );

    sfs_short_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_n_i (sleep_n_i),
        .ocp_evt_i (ocp_evt_i),
        .ocp_gnd_i (ocp_gnd_i),
        .latched_o (latched)
    );

    sfs_out_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .drv_disable_i (drv_disable_i),
        .sleep_n_i     (sleep_n_i),
        .xlat_rst_n_i  (xlat_rst_n_i),
        .ocp_evt_i     (ocp_evt_i),
        .ot_flag_i     (ot_flag_i),
        .uv_flag_i     (uv_flag_i),
        .latched_i     (latched),
        .ready_i       (ready),
        .out_en_o      (out_en_o),
        .home_rst_o    (home_rst_o),
        .step_block_o  (step_block_o),
        .fault_code_o  (fault_code_o)
    );

    assign fault_latched_o = latched;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       drv_disable_i,
    input logic       sleep_n_i,
    input logic       xlat_rst_n_i,
    input logic       ocp_evt_i,
    input logic       ocp_gnd_i,
    input logic       ot_flag_i,
    input logic       uv_flag_i,
    input logic       out_en_o,
    input logic       home_rst_o,
    input logic       step_block_o,
    input logic       fault_latched_o,
    input logic [1:0] fault_code_o
);
    // R1
    en_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_o |-> (!step_block_o && !fault_latched_o && fault_code_o == 2'd0));

    // R3
    wake_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_n_i && !$past(sleep_n_i)) |-> step_block_o);

    // R4
    short_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_evt_i && ocp_gnd_i) |=> fault_latched_o);

    // R5
    short_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_latched_o) && !fault_latched_o) |-> ($past(sleep_n_i) && !$past(sleep_n_i, 2)));

    // R6
    fault_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag_i || uv_flag_i) |-> !out_en_o);

    // R7
    reset_homes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_rst_n_i || !sleep_n_i || ocp_evt_i) |=> home_rst_o);

    // R8
    short_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched_o |-> fault_code_o == 2'd1);
endmodule

bind stepper_fault_supervisor sfs_checker u_chk (.*);

// File: tb/stepper_fault_supervisor_tb.sv
module stepper_fault_supervisor_tb;
    localparam int W = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dis = 1'b0, sl = 1'b1, rs = 1'b1, oe = 1'b0, og = 1'b0, ot = 1'b0, uv = 1'b0;
    logic       out_en, home, blk, lat;
    logic [1:0] code;
    int         tests = 0;
    int         fails = 0;

    always #5 clk = ~clk;

    stepper_fault_supervisor #(.WAKE_CYCLES(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .drv_disable_i(dis), .sleep_n_i(sl),
        .xlat_rst_n_i(rs), .ocp_evt_i(oe), .ocp_gnd_i(og), .ot_flag_i(ot),
        .uv_flag_i(uv), .out_en_o(out_en), .home_rst_o(home),
        .step_block_o(blk), .fault_latched_o(lat), .fault_code_o(code)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_wait();
        dis = 0; sl = 1; rs = 1; oe = 0; og = 0; ot = 0; uv = 0;
        repeat (W + 2) tick();
    endtask

    initial begin
        #(200000 * 10);
        fails++; tests++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R9: power-on reset state
        #12;
        check("R9 latch", lat, 0);
        check("R9 home", home, 1);
        check("R9 block", blk, 1);
        check("R9 out_en", out_en, 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        for (int j = 1; j <= W; j++) begin
            tick();
            check("R9 wake after reset", blk, (j < W) ? 1 : 0);
        end
        check("R9 out_en after wake", out_en, 1);
        tick();
        check("R7 home released", home, 0);

        // R1/R6/R7/R8 sweep over 32 combinations of the level inputs
        for (int v = 0; v < 32; v++) begin
            dis = v[0]; sl = v[1]; rs = v[2]; ot = v[3]; uv = v[4];
            #1;
            check("R1 out_en sweep", out_en, (!dis && sl && rs && !ot && !uv) ? 1 : 0);
            check("R8 code sweep", code, ot ? 2 : (uv ? 3 : 0));
            check("R2 block sweep", blk, sl ? 0 : 1);
            tick();
            check("R7 home sweep", home, (!rs || !sl || ot || uv) ? 1 : 0);
            idle_wait();
        end

        // R3 + R2: wake delay counted while disable pin is high
        sl = 0; tick(); tick();
        check("R3 block asleep", blk, 1);
        sl = 1; dis = 1;
        for (int j = 1; j <= W; j++) begin
            tick();
            check("R3 wake count", blk, (j < W) ? 1 : 0);
            check("R2 out_en off", out_en, 0);
        end
        dis = 0; #1;
        check("R2 out_en back", out_en, 1);
        // wake expiry under thermal fault
        sl = 0; tick(); sl = 1; ot = 1;
        repeat (W) tick();
        check("R6 block done under thermal", blk, 0);
        check("R6 out_en held", out_en, 0);
        ot = 0; #1;
        check("R6 immediate return", out_en, 1);
        idle_wait();

        // R7: plain over-current pulses home, no latch
        oe = 1; tick(); oe = 0; #1;
        check("R7 ocp home", home, 1);
        check("R4 no latch plain ocp", lat, 0);
        tick();
        check("R7 home drops", home, 0);

        // R4: short latches and persists
        oe = 1; og = 1; tick(); oe = 0; og = 0; #1;
        check("R4 latched", lat, 1);
        check("R4 out_en", out_en, 0);
        check("R8 short code", code, 1);
        ot = 1; uv = 1; #1;
        check("R8 priority short", code, 1);
        ot = 0; uv = 0;
        dis = 1; rs = 0; tick(); tick(); dis = 0; rs = 1; tick();
        check("R4 persists", lat, 1);
        check("R2 no enable effect on latch", lat, 1);

        // R5: sleep toggle clears
        sl = 0; tick(); tick();
        check("R5 held asleep", lat, 1);
        sl = 1; tick();
        check("R5 cleared", lat, 0);
        check("R3 wake pending", blk, 1);
        idle_wait();
        check("R5 out_en after wake", out_en, 1);

        // R5: set wins over clear on the same edge
        oe = 1; og = 1; tick(); oe = 0; og = 0;
        sl = 0; tick(); tick();
        sl = 1; oe = 1; og = 1; tick(); oe = 0; og = 0; #1;
        check("R5 set beats clear", lat, 1);
        check("R8 code after collision", code, 1);
        tick();
        check("R5 still latched", lat, 1);
        sl = 0; tick(); sl = 1; tick();
        check("R5 cleared later", lat, 0);
        idle_wait();

        // R6: undervoltage only, no latch
        uv = 1; #1;
        check("R6 uv gates", out_en, 0);
        check("R8 uv code", code, 3);
        ot = 1; #1;
        check("R8 thermal over uv", code, 2);
        tick(); ot = 0; uv = 0; #1;
        check("R6 no latch", lat, 0);
        check("R6 uv return", out_en, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule